// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block runs the exception path of a small 16-bit processor. It owns the registers that exist only for exception handling: the saved program counter, the saved status word, a scratch register for the handler, the number of the last exception and the base of the vector table. It also owns a 7-bit extension of the program counter. This extension is kept twice: once for the code currently running and once as a copy saved on exception entry.

An exception starts in one of two ways. A hardware interrupt is taken at an instruction boundary when its enable bit in the status word is set. A software trap names its exception number in the register field of the instruction. On entry the controller saves the PC, status and PC extension, and it writes back the status word with both interrupt enables cleared. It then reads the handler address through a request/acknowledge memory port and loads it into the PC with the extension cleared. Last, it pulses a refetch request. The return operation reverses the save. It also places the scratch register into a named destination register. The remaining special operations read or write the owned registers through the same destination and source paths.

Top module: `exc_ctrl`

## Requirements
- R1: After reset all owned registers read as zero, `busy` is low, `pc_high` is zero and no write strobe or refetch is asserted.
- R2: A hardware interrupt starts entry only when the block is idle, `boundary` is high, `op_valid` is low and its enable bit is set in `cur_sr` (bit 0 for `irq0`, bit 1 for `irq1`). When both qualify, `irq0` wins. The exception number is `IRQ0_NUM` (default 2) or `IRQ1_NUM` (default 3).
- R3: Operation code 1 (trap) starts entry with the exception number equal to `op_reg`, zero-extended.
- R4: In the cycle after entry is accepted, the block saves `cur_pc` minus 2 (modulo 2^16) as the exception PC, `cur_sr` as the exception status and the current PC extension as the saved extension. In the next cycle it presents a status write of `cur_sr` with bits 1 and 0 cleared.
- R5: The block then holds `mem_req` high with `mem_addr` = (vector base + 2 × exception number) modulo 2^16 until `mem_ack`. In the cycle after the acknowledge it writes `mem_rdata` to the PC, shows `pc_high` = 0 and pulses `refetch`, and in the cycle after that it is idle.
- R6: `busy` is high from the cycle after acceptance through the refetch cycle. While busy, operations and interrupts are ignored.
- R7: Operation code 0 (return) presents, one cycle later, a PC write of the exception PC, a status write of the exception status, a destination write of the scratch register to `op_reg`, and `refetch`. From then on `pc_high` equals the saved extension.
- R8: Code 4 writes {1'b0, saved extension, 1'b0, current extension} to destination `op_reg` one cycle later. Code 5 loads the current extension from `op_data[6:0]` and the saved one from `op_data[14:8]`, and pulses `refetch` one cycle later.
- R9: Odd codes 7, 9, 11, 13 and 15 store `op_data` into the exception PC, exception status, scratch register, exception number and vector base respectively. The even code just below each one writes that register to destination `op_reg` one cycle later.
- R10: Codes 2 and 3 produce no strobe and change no owned register.
- R11: When a valid operation and a qualifying interrupt arrive in the same idle cycle, the operation executes. The interrupt is taken in a later idle cycle if it is still pending then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Core is between instructions |
| irq0 | input | 1 | Interrupt request, higher priority |
| irq1 | input | 1 | Interrupt request, lower priority |
| cur_pc | input | 16 | Current PC value |
| cur_sr | input | 16 | Current status word |
| op_valid | input | 1 | Special operation issued this cycle |
| op_code | input | 4 | Special operation code |
| op_reg | input | 4 | Register field of the operation |
| op_data | input | 16 | Value of the named register, for set operations |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 16 | Vector read address |
| mem_ack | input | 1 | Vector read acknowledge |
| mem_rdata | input | 16 | Vector read data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 16 | PC write value |
| sr_we | output | 1 | Status write strobe |
| sr_wdata | output | 16 | Status write value |
| dst_we | output | 1 | Destination register write strobe |
| dst_sel | output | 4 | Destination register index |
| dst_wdata | output | 16 | Destination write value |
| refetch | output | 1 | Instruction fetch must restart |
| busy | output | 1 | Entry sequence in progress |
| pc_high | output | 7 | Current PC extension |

## Verification
A special operation and a hardware interrupt can both present themselves in one idle cycle. The bench provokes this by raising a register read, and in another case an extension write, in the same cycle as a qualifying `irq0` at a boundary. A behavioural model predicts every port on every clock: the operation's write lands one cycle later, and the entry sequence starts one cycle after that while the request is still held. The bench also issues operations and interrupts while the vector read is stalled. A later read-back must show that the owned registers kept their values.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

    localparam int WORD_W = 16;
    localparam int HI_W   = 7;
    localparam int RIDX_W = 4;
    localparam int OPC_W  = 4;
    localparam int IE0_BIT = 0;
    localparam int IE1_BIT = 1;
    localparam int HI_SAVED_LSB = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    // Operation codes: the decoder outside relies on these values.
    typedef enum logic [OPC_W-1:0] {
        SOP_RETI    = 4'h0,
        SOP_TRAP    = 4'h1,
        SOP_RSV_A   = 4'h2,
        SOP_RSV_B   = 4'h3,
        SOP_GET_HI  = 4'h4,
        SOP_SET_HI  = 4'h5,
        SOP_GET_EPC = 4'h6,
        SOP_SET_EPC = 4'h7,
        SOP_GET_ESR = 4'h8,
        SOP_SET_ESR = 4'h9,
        SOP_GET_EUR = 4'hA,
        SOP_SET_EUR = 4'hB,
        SOP_GET_NUM = 4'hC,
        SOP_SET_NUM = 4'hD,
        SOP_GET_VBR = 4'hE,
        SOP_SET_VBR = 4'hF
    } sop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_VREAD,
        ST_FETCH
    } est_e;

    typedef struct packed {
        logic  we;
        word_t data;
    } wr_t;

    typedef struct packed {
        logic  we;
        ridx_t sel;
        word_t data;
    } dwr_t;

    function automatic word_t vec_addr(word_t base, word_t num);
        return base + {num[WORD_W-2:0], 1'b0};
    endfunction

    function automatic word_t pack_hi(hi_t cur, hi_t saved);
        word_t r;
        r = '0;
        r[HI_W-1:0] = cur;
        r[HI_SAVED_LSB+HI_W-1:HI_SAVED_LSB] = saved;
        return r;
    endfunction

    function automatic word_t mask_ie(word_t sr);
        word_t r;
        r = sr;
        r[IE0_BIT] = 1'b0;
        r[IE1_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int IRQ0_NUM = 2,
    parameter int IRQ1_NUM = 3
) (
    input  logic             idle,
    input  logic             boundary,
    input  logic             irq0,
    input  logic             irq1,
    input  word_t            cur_sr,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  ridx_t            op_reg,
    output logic             op_go,
    output logic             take,
    output word_t            take_num
);

    localparam word_t NUM0 = word_t'(IRQ0_NUM);
    localparam word_t NUM1 = word_t'(IRQ1_NUM);

    always_comb begin
        op_go    = idle && op_valid;
        take     = 1'b0;
        take_num = '0;
        if (op_go) begin
            if (sop_e'(op_code) == SOP_TRAP) begin
                take     = 1'b1;
                take_num = word_t'(op_reg);
            end
        end else if (idle && boundary) begin
            if (irq0 && cur_sr[IE0_BIT]) begin
                take     = 1'b1;
                take_num = NUM0;
            end else if (irq1 && cur_sr[IE1_BIT]) begin
                take     = 1'b1;
                take_num = NUM1;
            end
        end
    end

endmodule

// File: rtl/exc_sregs.sv
`timescale 1ns/1ps
module exc_sregs
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             num_en,
    input  word_t            num_in,
    input  logic             save_en,
    input  word_t            save_pc,
    input  word_t            save_sr,
    input  logic             clr_hi,
    input  logic             restore_hi,
    input  logic             set_en,
    input  logic [OPC_W-1:0] op_code,
    input  word_t            set_data,
    output word_t            get_data,
    output word_t            epc,
    output word_t            esr,
    output word_t            eur,
    output word_t            exc_num,
    output word_t            vbr,
    output hi_t              cur_hi
);

    hi_t saved_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc      <= '0;
            esr      <= '0;
            eur      <= '0;
            exc_num  <= '0;
            vbr      <= '0;
            cur_hi   <= '0;
            saved_hi <= '0;
        end else begin
            if (num_en) begin
                exc_num <= num_in;
            end
            if (save_en) begin
                epc      <= save_pc - word_t'(2);
                esr      <= save_sr;
                saved_hi <= cur_hi;
            end
            if (clr_hi) begin
                cur_hi <= '0;
            end
            if (restore_hi) begin
                cur_hi <= saved_hi;
            end
            if (set_en) begin
                case (sop_e'(op_code))
                    SOP_SET_HI: begin
                        cur_hi   <= set_data[HI_W-1:0];
                        saved_hi <= set_data[HI_SAVED_LSB+HI_W-1:HI_SAVED_LSB];
                    end
                    SOP_SET_EPC: epc     <= set_data;
                    SOP_SET_ESR: esr     <= set_data;
                    SOP_SET_EUR: eur     <= set_data;
                    SOP_SET_NUM: exc_num <= set_data;
                    SOP_SET_VBR: vbr     <= set_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sop_e'(op_code))
            SOP_GET_HI:  get_data = pack_hi(cur_hi, saved_hi);
            SOP_GET_EPC: get_data = epc;
            SOP_GET_ESR: get_data = esr;
            SOP_GET_EUR: get_data = eur;
            SOP_GET_NUM: get_data = exc_num;
            SOP_GET_VBR: get_data = vbr;
            default:     get_data = '0;
        endcase
    end

endmodule

// File: rtl/exc_seq.sv
`timescale 1ns/1ps
module exc_seq
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_go,
    input  logic             take,
    input  logic [OPC_W-1:0] op_code,
    input  ridx_t            op_reg,
    input  word_t            cur_sr,
    input  word_t            get_data,
    input  word_t            epc,
    input  word_t            esr,
    input  word_t            eur,
    input  logic             mem_ack,
    input  word_t            mem_rdata,
    output est_e             state,
    output logic             save_en,
    output logic             clr_hi,
    output logic             restore_hi,
    output wr_t              pc_wr,
    output wr_t              sr_wr,
    output dwr_t             dst_wr,
    output logic             refetch
);

    sop_e code;
    logic is_get;

    always_comb begin
        code       = sop_e'(op_code);
        is_get     = (code == SOP_GET_HI)  || (code == SOP_GET_EPC) ||
                     (code == SOP_GET_ESR) || (code == SOP_GET_EUR) ||
                     (code == SOP_GET_NUM) || (code == SOP_GET_VBR);
        save_en    = (state == ST_SAVE);
        clr_hi     = (state == ST_VREAD) && mem_ack;
        restore_hi = op_go && (code == SOP_RETI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc_wr   <= '0;
            sr_wr   <= '0;
            dst_wr  <= '0;
            refetch <= 1'b0;
        end else begin
            pc_wr.we  <= 1'b0;
            sr_wr.we  <= 1'b0;
            dst_wr.we <= 1'b0;
            refetch   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        state <= ST_SAVE;
                    end else if (op_go) begin
                        if (code == SOP_RETI) begin
                            pc_wr   <= '{we: 1'b1, data: epc};
                            sr_wr   <= '{we: 1'b1, data: esr};
                            dst_wr  <= '{we: 1'b1, sel: op_reg, data: eur};
                            refetch <= 1'b1;
                        end else if (is_get) begin
                            dst_wr  <= '{we: 1'b1, sel: op_reg, data: get_data};
                        end else if (code == SOP_SET_HI) begin
                            refetch <= 1'b1;
                        end
                    end
                end
                ST_SAVE: begin
                    sr_wr <= '{we: 1'b1, data: mask_ie(cur_sr)};
                    state <= ST_VREAD;
                end
                ST_VREAD: begin
                    if (mem_ack) begin
                        pc_wr   <= '{we: 1'b1, data: mem_rdata};
                        refetch <= 1'b1;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/exc_ctrl.sv
`timescale 1ns/1ps
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int IRQ0_NUM = 2,
    parameter int IRQ1_NUM = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic        irq0,
    input  logic        irq1,
    input  logic [15:0] cur_pc,
    input  logic [15:0] cur_sr,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [3:0]  op_reg,
    input  logic [15:0] op_data,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic        pc_we,
    output logic [15:0] pc_wdata,
    output logic        sr_we,
    output logic [15:0] sr_wdata,
    output logic        dst_we,
    output logic [3:0]  dst_sel,
    output logic [15:0] dst_wdata,
    output logic        refetch,
    output logic        busy,
    output logic [6:0]  pc_high
);

    est_e  state;
    logic  op_go, take, save_en, clr_hi, restore_hi;
    word_t take_num, get_data, epc, esr, eur, exc_num, vbr;
    hi_t   cur_hi;
    wr_t   pc_wr, sr_wr;
    dwr_t  dst_wr;

    exc_arbiter #(
        .IRQ0_NUM (IRQ0_NUM),
        .IRQ1_NUM (IRQ1_NUM)
    ) u_arb (
        .idle     (state == ST_IDLE),
        .boundary (boundary),
        .irq0     (irq0),
        .irq1     (irq1),
        .cur_sr   (cur_sr),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_reg   (op_reg),
        .op_go    (op_go),
        .take     (take),
        .take_num (take_num)
    );

    exc_sregs u_regs (
        .clk        (clk),
        .rst        (rst),
        .num_en     (take),
        .num_in     (take_num),
        .save_en    (save_en),
        .save_pc    (cur_pc),
        .save_sr    (cur_sr),
        .clr_hi     (clr_hi),
        .restore_hi (restore_hi),
        .set_en     (op_go),
        .op_code    (op_code),
        .set_data   (op_data),
        .get_data   (get_data),
        .epc        (epc),
        .esr        (esr),
        .eur        (eur),
        .exc_num    (exc_num),
        .vbr        (vbr),
        .cur_hi     (cur_hi)
    );

    exc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .op_go      (op_go),
        .take       (take),
        .op_code    (op_code),
        .op_reg     (op_reg),
        .cur_sr     (cur_sr),
        .get_data   (get_data),
        .epc        (epc),
        .esr        (esr),
        .eur        (eur),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .save_en    (save_en),
        .clr_hi     (clr_hi),
        .restore_hi (restore_hi),
        .pc_wr      (pc_wr),
        .sr_wr      (sr_wr),
        .dst_wr     (dst_wr),
        .refetch    (refetch)
    );

    assign mem_req   = (state == ST_VREAD);
    assign mem_addr  = vec_addr(vbr, exc_num);
    assign busy      = (state != ST_IDLE);
    assign pc_high   = cur_hi;
    assign pc_we     = pc_wr.we;
    assign pc_wdata  = pc_wr.data;
    assign sr_we     = sr_wr.we;
    assign sr_wdata  = sr_wr.data;
    assign dst_we    = dst_wr.we;
    assign dst_sel   = dst_wr.sel;
    assign dst_wdata = dst_wr.data;

endmodule

// File: rtl/exc_ctrl_chk.sv
`timescale 1ns/1ps
module exc_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        boundary,
    input logic        irq0,
    input logic        cur_sr0,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ack,
    input logic        pc_we,
    input logic        sr_we,
    input logic [1:0]  sr_ie,
    input logic        refetch,
    input logic        busy,
    input logic [6:0]  pc_high
);

    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    vec_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (pc_we && refetch && pc_high == 7'd0 && !mem_req));

    // R4
    mask_ie_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_we && !refetch) |-> (sr_ie == 2'b00));

    // R2
    irq_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && boundary && !op_valid && irq0 && cur_sr0) |=> busy);

    // R11
    op_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_valid && op_code != 4'h1) |=> !busy);

    // R8
    hi_refetch_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_valid && op_code == 4'h5) |=> refetch);

    // R6
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

endmodule

bind exc_ctrl exc_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .irq0     (irq0),
    .cur_sr0  (cur_sr[0]),
    .op_valid (op_valid),
    .op_code  (op_code),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .pc_we    (pc_we),
    .sr_we    (sr_we),
    .sr_ie    (sr_wdata[1:0]),
    .refetch  (refetch),
    .busy     (busy),
    .pc_high  (pc_high)
);

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary = 1'b0, irq0 = 1'b0, irq1 = 1'b0;
    logic [15:0] cur_pc = 16'h0, cur_sr = 16'h0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'h0, op_reg = 4'h0;
    logic [15:0] op_data = 16'h0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic        pc_we, sr_we, dst_we, refetch, busy;
    logic [15:0] pc_wdata, sr_wdata, dst_wdata;
    logic [3:0]  dst_sel;
    logic [6:0]  pc_high;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    int    ack_lat = 1;
    int    wait_n = 0;
    string cur_req = "R1";

    exc_ctrl uut (
        .clk(clk), .rst(rst), .boundary(boundary), .irq0(irq0), .irq1(irq1),
        .cur_pc(cur_pc), .cur_sr(cur_sr), .op_valid(op_valid), .op_code(op_code),
        .op_reg(op_reg), .op_data(op_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .dst_we(dst_we), .dst_sel(dst_sel),
        .dst_wdata(dst_wdata), .refetch(refetch), .busy(busy), .pc_high(pc_high)
    );

    always #10 clk = ~clk;

    // Behavioural reference: mode 0 idle, 1 saving, 2 awaiting vector, 3 refetch
    int          m_mode;
    logic [15:0] m_epc, m_esr, m_eur, m_num, m_vbr;
    logic [6:0]  m_hi, m_shi;
    logic        e_pcwe, e_srwe, e_dwe, e_rf;
    logic [15:0] e_pcwd, e_srwd, e_dwd;
    logic [3:0]  e_dsel;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_epc = 0; m_esr = 0; m_eur = 0; m_num = 0; m_vbr = 0;
            m_hi = 0; m_shi = 0;
            e_pcwe = 0; e_srwe = 0; e_dwe = 0; e_rf = 0;
            e_pcwd = 0; e_srwd = 0; e_dwd = 0; e_dsel = 0;
        end else begin
            e_pcwe = 0; e_srwe = 0; e_dwe = 0; e_rf = 0;
            if (m_mode == 0) begin
                if (op_valid) begin
                    e_dsel = op_reg;
                    case (op_code)
                        4'h0: begin
                            e_pcwe = 1; e_pcwd = m_epc; e_srwe = 1; e_srwd = m_esr;
                            e_dwe = 1; e_dwd = m_eur; e_rf = 1; m_hi = m_shi;
                        end
                        4'h1: begin m_num = {12'h000, op_reg}; m_mode = 1; end
                        4'h4: begin e_dwe = 1; e_dwd = {1'b0, m_shi, 1'b0, m_hi}; end
                        4'h5: begin m_hi = op_data[6:0]; m_shi = op_data[14:8]; e_rf = 1; end
                        4'h6: begin e_dwe = 1; e_dwd = m_epc; end
                        4'h7: m_epc = op_data;
                        4'h8: begin e_dwe = 1; e_dwd = m_esr; end
                        4'h9: m_esr = op_data;
                        4'hA: begin e_dwe = 1; e_dwd = m_eur; end
                        4'hB: m_eur = op_data;
                        4'hC: begin e_dwe = 1; e_dwd = m_num; end
                        4'hD: m_num = op_data;
                        4'hE: begin e_dwe = 1; e_dwd = m_vbr; end
                        4'hF: m_vbr = op_data;
                        default: ;
                    endcase
                end else if (boundary && irq0 && cur_sr[0]) begin
                    m_num = 16'd2; m_mode = 1;
                end else if (boundary && irq1 && cur_sr[1]) begin
                    m_num = 16'd3; m_mode = 1;
                end
            end else if (m_mode == 1) begin
                m_epc = cur_pc - 16'd2; m_esr = cur_sr; m_shi = m_hi;
                e_srwe = 1; e_srwd = cur_sr & 16'hFFFC; m_mode = 2;
            end else if (m_mode == 2) begin
                if (mem_ack) begin
                    e_pcwe = 1; e_pcwd = mem_rdata; e_rf = 1; m_hi = 0; m_mode = 3;
                end
            end else begin
                m_mode = 0;
            end
        end
    end

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare every port against the model, then play the memory side
    always @(negedge clk) begin
        if (!rst) begin
            int va;
            va = (int'(m_vbr) + 2 * int'(m_num)) & 16'hFFFF;
            chk("busy", {15'h0, busy}, {15'h0, m_mode != 0});
            chk("mem_req", {15'h0, mem_req}, {15'h0, m_mode == 2});
            if (m_mode == 2) chk("mem_addr", mem_addr, va[15:0]);
            chk("pc_high", {9'h0, pc_high}, {9'h0, m_hi});
            chk("pc_we", {15'h0, pc_we}, {15'h0, e_pcwe});
            if (e_pcwe) chk("pc_wdata", pc_wdata, e_pcwd);
            chk("sr_we", {15'h0, sr_we}, {15'h0, e_srwe});
            if (e_srwe) chk("sr_wdata", sr_wdata, e_srwd);
            chk("dst_we", {15'h0, dst_we}, {15'h0, e_dwe});
            if (e_dwe) begin
                chk("dst_sel", {12'h0, dst_sel}, {12'h0, e_dsel});
                chk("dst_wdata", dst_wdata, e_dwd);
            end
            chk("refetch", {15'h0, refetch}, {15'h0, e_rf});
        end
        mem_ack = 1'b0;
        if (mem_req && !rst) begin
            if (wait_n >= ack_lat) begin
                mem_ack = 1'b1;
                mem_rdata = mem_addr ^ 16'h5A5A;
                wait_n = 0;
            end else begin
                wait_n++;
            end
        end else begin
            wait_n = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic do_op(logic [3:0] code, logic [3:0] rsel, logic [15:0] data);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_reg = rsel; op_data = data;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_get(logic [3:0] code, logic [3:0] rsel, logic [15:0] exp);
        do_op(code, rsel, 16'h0);
        chk("direct dst_we", {15'h0, dst_we}, 16'h0001);
        chk("direct dst_wdata", dst_wdata, exp);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic raise_irq(logic a, logic b);
        @(negedge clk);
        boundary = 1'b1; irq0 = a; irq1 = b;
        @(negedge clk);
        boundary = 1'b0; irq0 = 1'b0; irq1 = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("reset busy", {15'h0, busy}, 16'h0);
        chk("reset pc_high", {9'h0, pc_high}, 16'h0);
        expect_get(4'hE, 4'h3, 16'h0000);
        expect_get(4'h4, 4'h3, 16'h0000);

        cur_req = "R9";
        do_op(4'hF, 4'h1, 16'hFFF0);
        do_op(4'hB, 4'h1, 16'hBEEF);
        expect_get(4'hE, 4'h5, 16'hFFF0);
        expect_get(4'hA, 4'h6, 16'hBEEF);
        do_op(4'h7, 4'h1, 16'h4444);
        expect_get(4'h6, 4'h2, 16'h4444);
        do_op(4'h9, 4'h1, 16'h0F0F);
        expect_get(4'h8, 4'h2, 16'h0F0F);
        do_op(4'hD, 4'h1, 16'h0009);
        expect_get(4'hC, 4'h2, 16'h0009);

        cur_req = "R8";
        do_op(4'h5, 4'h0, 16'hAA95);
        chk("hi current", {9'h0, pc_high}, 16'h0015);
        expect_get(4'h4, 4'h7, 16'h2A15);

        cur_req = "R4";
        cur_pc = 16'h1234; cur_sr = 16'h7F03; ack_lat = 3;
        raise_irq(1'b1, 1'b0);
        expect_get(4'h6, 4'h1, 16'h1232);
        expect_get(4'h8, 4'h1, 16'h7F03);
        expect_get(4'h4, 4'h1, 16'h1500);
        cur_req = "R2";
        expect_get(4'hC, 4'h1, 16'h0002);

        cur_req = "R7";
        do_op(4'h0, 4'hD, 16'h0);
        chk("return restores hi", {9'h0, pc_high}, 16'h0015);

        cur_req = "R3";
        cur_pc = 16'h0000; ack_lat = 0;
        do_op(4'h1, 4'hF, 16'h0);
        wait_idle();
        expect_get(4'hC, 4'h1, 16'h000F);
        cur_req = "R5";
        expect_get(4'h6, 4'h1, 16'hFFFE);

        cur_req = "R2";
        cur_sr = 16'h0000;
        raise_irq(1'b1, 1'b1);
        cur_sr = 16'h0002;
        raise_irq(1'b1, 1'b1);
        expect_get(4'hC, 4'h1, 16'h0003);
        cur_sr = 16'h0003;
        raise_irq(1'b1, 1'b1);
        expect_get(4'hC, 4'h1, 16'h0002);
        @(negedge clk);
        irq0 = 1'b1; boundary = 1'b0;
        repeat (3) @(negedge clk);
        irq0 = 1'b0;
        chk("no entry without boundary", {15'h0, busy}, 16'h0);

        cur_req = "R11";
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'hE; op_reg = 4'h4;
        boundary = 1'b1; irq0 = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        boundary = 1'b0; irq0 = 1'b0;
        wait_idle();
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'h5; op_reg = 4'h0; op_data = 16'h0102;
        boundary = 1'b1; irq1 = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        boundary = 1'b0; irq1 = 1'b0;
        wait_idle();

        cur_req = "R6";
        ack_lat = 6;
        do_op(4'h1, 4'h4, 16'h0);
        do_op(4'hF, 4'h1, 16'h1111);
        @(negedge clk);
        boundary = 1'b1; irq0 = 1'b1;
        @(negedge clk);
        boundary = 1'b0; irq0 = 1'b0;
        wait_idle();
        expect_get(4'hE, 4'h1, 16'hFFF0);
        expect_get(4'hC, 4'h1, 16'h0004);

        cur_req = "R10";
        do_op(4'h2, 4'h1, 16'h7777);
        chk("reserved no dst", {15'h0, dst_we}, 16'h0);
        do_op(4'h3, 4'h1, 16'h7777);
        chk("reserved no pc", {15'h0, pc_we}, 16'h0);
        expect_get(4'hE, 4'h1, 16'hFFF0);
        expect_get(4'hA, 4'h1, 16'hBEEF);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule